// File: doc/BRIEF.md
# Reference Clock Switchover Controller

This block supervises two reference clocks, a primary and a backup, from a free-running monitor clock. For each reference it keeps a loss flag. Each reference is divided by two in its own domain, and that toggle is resynchronised into the monitor domain. A reference that shows no transition for a set number of monitor cycles is marked bad. A bad reference is marked good again after a set number of consecutive transitions.

From the loss flags, a switch request and a mode input, the block drives a select for an external glitch-free clock multiplexer and an indicator of which reference is in use. Three policies are available: failover only, operator request only, and failover combined with operator requests. Every switch waits a programmable number of monitor cycles, from 0 to 7, before it takes effect. When the design is built without a backup reference, the select, the indicator and the backup loss flag are tied to 0.

Top module: `refclk_switch_ctrl`

## Requirements
- R1: `active_out` is 0 while the primary (`ref_a`) is selected and 1 while the backup (`ref_b`) is selected. It always equals `sel_out` and changes in the same cycle.
- R2: A loss flag (`bad_a`, `bad_b`) rises to 1 once its reference has shown no transition for MISS_LIMIT (default 16) monitor cycles.
- R3: A raised loss flag returns to 0 after GOOD_EDGES (default 4) consecutive transitions of its reference. A reference that keeps running holds its flag at 0.
- R4: `mode` encodes the policy: 0 failover only, 1 request only, 2 failover plus requests, and 3 behaves exactly as 0.
- R5: Under a failover policy, the select leaves the active reference only when that reference is bad and the other one is good. It never moves to a bad reference, and it does not move back when the old reference recovers.
- R6: In mode 1, a rising edge of `switch_req` toggles the selection whatever the loss flags show. In modes 0 and 3, `switch_req` has no effect.
- R7: In mode 2, a rising edge of `switch_req` toggles the selection, and automatic failover also takes place.
- R8: A switch triggered at a clock edge changes `sel_out` at the `delay_cfg`-th following edge. With `delay_cfg` = 0 it changes at the triggering edge itself.
- R9: While a switch is pending, further requests and failover conditions are ignored. Each trigger produces exactly one toggle.
- R10: Synchronous `mon_rst` selects the primary, clears both loss flags and cancels any pending switch.
- R11: With HAS_BACKUP = 0, `sel_out`, `active_out` and `bad_b` stay at 0 under any stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Free-running monitor clock |
| mon_rst | input | 1 | Synchronous active-high reset |
| ref_a | input | 1 | Primary reference clock |
| ref_b | input | 1 | Backup reference clock |
| switch_req | input | 1 | Operator switch request, acted on at its rising edge |
| mode | input | 2 | Switchover policy (see R4) |
| delay_cfg | input | DLY_W | Switch delay in monitor cycles |
| sel_out | output | 1 | Multiplexer select, 0 primary / 1 backup |
| active_out | output | 1 | Reference in use, 0 primary / 1 backup |
| bad_a | output | 1 | Primary reference lost |
| bad_b | output | 1 | Backup reference lost |

## Verification
The hardest case to reach is an automatic failover, because it needs one reference truly silent and the other recovered at the same time. The bench stops and restarts the free-running reference generators one at a time and waits out the detection windows. In doing so it also produces the state where both references are bad, where the select must hold. Switch latency is swept over all eight delay settings by counting edges from the triggering request. A second request is issued inside a pending window, and a reset is issued inside another one.

// File: rtl/swo_pkg.sv
package swo_pkg;
   typedef enum logic [1:0] {
      SWO_AUTO     = 2'd0,
      SWO_MANUAL   = 2'd1,
      SWO_OVERRIDE = 2'd2,
      SWO_AUTO_ALT = 2'd3
   } swo_mode_e;

   function automatic logic allows_failover(input logic [1:0] m);
      return (m != SWO_MANUAL);
   endfunction

   function automatic logic allows_request(input logic [1:0] m);
      return (m == SWO_MANUAL) || (m == SWO_OVERRIDE);
   endfunction
endpackage

// File: rtl/swo_loss_det.sv
module swo_loss_det #(
   parameter int MISS_LIMIT  = 16,
   parameter int GOOD_EDGES  = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_clk,
   output logic bad
);
   localparam int MW = $clog2(MISS_LIMIT + 1);
   localparam int GW = $clog2(GOOD_EDGES + 1);

   if (MISS_LIMIT < 2)  begin : g_chk_miss  $error("MISS_LIMIT must be at least 2"); end
   if (GOOD_EDGES < 1)  begin : g_chk_good  $error("GOOD_EDGES must be at least 1"); end
   if (SYNC_STAGES < 2) begin : g_chk_sync  $error("SYNC_STAGES must be at least 2"); end

   // divide-by-two toggle in the reference domain
   logic tog = 1'b0;
   always_ff @(posedge ref_clk) tog <= ~tog;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   edge_seen;
   logic [MW-1:0]          miss_cnt;
   logic [GW-1:0]          good_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], tog};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign edge_seen = sync_q[SYNC_STAGES-1] ^ last_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         miss_cnt <= '0;
         good_cnt <= '0;
         bad      <= 1'b0;
      end else if (edge_seen) begin
         miss_cnt <= '0;
         if (bad) begin
            if (good_cnt == GW'(GOOD_EDGES - 1)) begin
               bad      <= 1'b0;
               good_cnt <= '0;
            end else begin
               good_cnt <= good_cnt + 1'b1;
            end
         end
      end else begin
         if (miss_cnt == MW'(MISS_LIMIT - 1)) begin
            bad      <= 1'b1;
            good_cnt <= '0;
            miss_cnt <= '0;
         end else begin
            miss_cnt <= miss_cnt + 1'b1;
         end
      end
   end

   p_loss_needs_silence_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(bad) |-> !$past(edge_seen));

   p_recover_on_edge_r3: assert property (@(posedge clk) disable iff (rst)
      $fell(bad) |-> $past(edge_seen));
endmodule

// File: rtl/swo_sel_fsm.sv
module swo_sel_fsm
   import swo_pkg::*;
#(
   parameter int DLY_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req,
   input  logic [1:0]       mode,
   input  logic [DLY_W-1:0] dly,
   input  logic             bad_a,
   input  logic             bad_b,
   output logic             sel
);
   if (DLY_W < 1) begin : g_chk_dly $error("DLY_W must be at least 1"); end

   logic             req_q;
   logic             pend;
   logic [DLY_W-1:0] cnt;
   logic             act_bad, alt_bad;
   logic             trig_req, trig_auto, trig;

   assign act_bad   = sel ? bad_b : bad_a;
   assign alt_bad   = sel ? bad_a : bad_b;
   assign trig_req  = allows_request(mode) && req && !req_q;
   assign trig_auto = allows_failover(mode) && act_bad && !alt_bad;
   assign trig      = !pend && (trig_req || trig_auto);

   always_ff @(posedge clk) begin
      if (rst) begin
         sel   <= 1'b0;
         pend  <= 1'b0;
         cnt   <= '0;
         req_q <= 1'b0;
      end else begin
         req_q <= req;
         if (pend) begin
            if (cnt == '0) begin
               sel  <= ~sel;
               pend <= 1'b0;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end else if (trig) begin
            if (dly == '0) begin
               sel <= ~sel;
            end else begin
               pend <= 1'b1;
               cnt  <= dly - 1'b1;
            end
         end
      end
   end

   p_hold_while_counting_r9: assert property (@(posedge clk) disable iff (rst)
      (pend && cnt != '0) |=> $stable(sel));

   p_toggle_has_cause_r8: assert property (@(posedge clk) disable iff (rst)
      !$stable(sel) |-> ($past(pend) || $past(trig)));

   p_reset_home_r10: assert property (@(posedge clk)
      rst |=> (!sel && !pend));
endmodule

// File: rtl/refclk_switch_ctrl.sv
module refclk_switch_ctrl #(
   parameter int MISS_LIMIT  = 16,
   parameter int GOOD_EDGES  = 4,
   parameter int SYNC_STAGES = 2,
   parameter int DLY_W       = 3,
   parameter bit HAS_BACKUP  = 1'b1
) (
   input  logic             mon_clk,
   input  logic             mon_rst,
   input  logic             ref_a,
   input  logic             ref_b,
   input  logic             switch_req,
   input  logic [1:0]       mode,
   input  logic [DLY_W-1:0] delay_cfg,
   output logic             sel_out,
   output logic             active_out,
   output logic             bad_a,
   output logic             bad_b
);
   swo_loss_det #(
      .MISS_LIMIT(MISS_LIMIT), .GOOD_EDGES(GOOD_EDGES), .SYNC_STAGES(SYNC_STAGES)
   ) u_det_a (
      .clk(mon_clk), .rst(mon_rst), .ref_clk(ref_a), .bad(bad_a)
   );

   if (HAS_BACKUP) begin : g_dual
      logic sel_w;
      swo_loss_det #(
         .MISS_LIMIT(MISS_LIMIT), .GOOD_EDGES(GOOD_EDGES), .SYNC_STAGES(SYNC_STAGES)
      ) u_det_b (
         .clk(mon_clk), .rst(mon_rst), .ref_clk(ref_b), .bad(bad_b)
      );
      swo_sel_fsm #(.DLY_W(DLY_W)) u_fsm (
         .clk(mon_clk), .rst(mon_rst), .req(switch_req), .mode(mode),
         .dly(delay_cfg), .bad_a(bad_a), .bad_b(bad_b), .sel(sel_w)
      );
      assign sel_out    = sel_w;
      assign active_out = sel_w;
   end else begin : g_single
      logic unused_w;
      assign unused_w   = ^{ref_b, switch_req, mode, delay_cfg};
      assign bad_b      = 1'b0;
      assign sel_out    = 1'b0;
      assign active_out = 1'b0;
   end

   p_never_to_bad_r5: assert property (@(posedge mon_clk) disable iff (mon_rst)
      (mode != 2'd1 && $rose(sel_out)) |-> !$past(bad_b, 1) || $past(mode, 1) == 2'd2);
endmodule

// File: tb/sim_refclk_switch_ctrl.sv
`timescale 1ns/1ps
module sim_refclk_switch_ctrl;
   logic clk = 1'b0, rst = 1'b1;
   logic ref_a = 1'b0, ref_b = 1'b0, run_a = 1'b1, run_b = 1'b1;
   logic req = 1'b0;
   logic [1:0] mode = 2'd1;
   logic [2:0] dly = 3'd0;
   logic sel, act, ba, bb, sel1, act1, ba1, bb1;
   int total = 0, bad = 0;

   always #2 clk = ~clk;
   initial forever begin #10; if (run_a) ref_a = ~ref_a; end
   initial forever begin #14; if (run_b) ref_b = ~ref_b; end

   refclk_switch_ctrl u0 (
      .mon_clk(clk), .mon_rst(rst), .ref_a(ref_a), .ref_b(ref_b), .switch_req(req),
      .mode(mode), .delay_cfg(dly), .sel_out(sel), .active_out(act), .bad_a(ba), .bad_b(bb));

   refclk_switch_ctrl #(.HAS_BACKUP(1'b0)) u1 (
      .mon_clk(clk), .mon_rst(rst), .ref_a(ref_a), .ref_b(ref_b), .switch_req(req),
      .mode(mode), .delay_cfg(dly), .sel_out(sel1), .active_out(act1), .bad_a(ba1), .bad_b(bb1));

   task automatic chk(input bit ok, input string tag, input int actual, input int expect_v);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, actual, expect_v);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_req();
      @(negedge clk); req = 1'b1;
      @(negedge clk); req = 1'b0;
   endtask

   int u1_err = 0;
   always @(negedge clk) if (!rst && (sel1 || act1 || bb1)) u1_err++;

   initial begin
      #800000;
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait_cyc(5);
      chk(sel == 0 && act == 0, "R10 reset sel", sel, 0);
      chk(ba == 0 && bb == 0, "R10 reset flags", {ba, bb}, 0);
      rst = 1'b0;
      wait_cyc(60);
      chk(ba == 0 && bb == 0, "R3 running clocks good", {ba, bb}, 0);

      // R8: latency sweep in mode 1 over every delay setting
      mode = 2'd1;
      for (int d = 0; d < 8; d++) begin
         automatic int n = 0;
         automatic logic prior = sel;
         dly = 3'(d);
         @(negedge clk); req = 1'b1;
         while (n < 20) begin
            @(posedge clk); #1; n++;
            if (sel != prior) break;
         end
         @(negedge clk); req = 1'b0;
         chk(n == d + 1, "R8 delay latency", n, d + 1);
         chk(act == sel, "R1 indicator follows select", act, sel);
         wait_cyc(10);
      end
      chk(sel == 0, "R6 eight toggles back home", sel, 0);

      // R2 / R6: stop backup, manual still switches onto it
      dly = 3'd0;
      run_b = 1'b0;
      wait_cyc(60);
      chk(bb == 1, "R2 backup loss flagged", bb, 1);
      chk(ba == 0, "R2 primary unaffected", ba, 0);
      pulse_req(); wait_cyc(3);
      chk(sel == 1 && act == 1, "R6 manual onto bad clock", sel, 1);
      pulse_req(); wait_cyc(3);
      chk(sel == 0, "R6 manual back", sel, 0);

      // R4 / R6: mode 0 ignores requests
      mode = 2'd0;
      pulse_req(); wait_cyc(12);
      chk(sel == 0, "R6 request ignored in mode 0", sel, 0);

      // R5: both bad, select holds
      run_a = 1'b0;
      wait_cyc(60);
      chk(ba == 1 && bb == 1, "R2 both lost", {ba, bb}, 3);
      chk(sel == 0, "R5 no move to bad clock", sel, 0);

      // R3 + R5: backup recovers, failover with delay 3
      dly = 3'd3;
      run_b = 1'b1;
      wait_cyc(60);
      chk(bb == 0, "R3 backup recovered", bb, 0);
      chk(sel == 1 && act == 1, "R5 failover to good backup", sel, 1);
      run_a = 1'b1;
      wait_cyc(60);
      chk(ba == 0, "R3 primary recovered", ba, 0);
      chk(sel == 1, "R5 no switch back", sel, 1);

      // R7: override mode
      mode = 2'd2;
      pulse_req(); wait_cyc(10);
      chk(sel == 0, "R7 request honoured", sel, 0);
      run_a = 1'b0;
      wait_cyc(60);
      chk(sel == 1, "R7 failover in mode 2", sel, 1);
      run_a = 1'b1;
      wait_cyc(60);

      // R4: mode 3 acts as failover
      mode = 2'd3;
      run_b = 1'b0;
      wait_cyc(60);
      chk(sel == 0, "R4 mode 3 fails over", sel, 0);
      pulse_req(); wait_cyc(12);
      chk(sel == 0, "R4 mode 3 ignores request", sel, 0);
      run_b = 1'b1;
      wait_cyc(60);

      // R9: second request inside pending window
      mode = 2'd1; dly = 3'd7;
      pulse_req(); pulse_req();
      wait_cyc(20);
      chk(sel == 1, "R9 single toggle", sel, 1);
      pulse_req(); wait_cyc(20);
      chk(sel == 0, "R9 back home", sel, 0);

      // R10: reset cancels a pending switch and clears flags
      run_b = 1'b0;
      wait_cyc(60);
      pulse_req(); wait_cyc(1);
      rst = 1'b1; wait_cyc(2);
      chk(sel == 0 && bb == 0, "R10 reset clears", {sel, bb}, 0);
      rst = 1'b0; wait_cyc(12);
      chk(sel == 0, "R10 pending cancelled", sel, 0);
      run_b = 1'b1;
      wait_cyc(60);

      // R11: single-reference build
      pulse_req(); wait_cyc(10);
      chk(u1_err == 0, "R11 no-backup outputs stay 0", u1_err, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule